// File: doc/BRIEF.md
# Integer ALU with Sticky Overflow Flags

This block is the integer execution stage of a small processor datapath. Each cycle it takes two operands, an operation code, a condition operand and the current value of the destination register. It returns the value to write and a write enable. The register file and the instruction decoder sit outside the block; the block does not read or write registers itself. The operations are wrapping and saturating add and subtract, a signed multiply that keeps the low word, conditional add, conditional move, equality and signed less-than compares, bitwise logic and a plain move.

Four status flags are kept in registers and change on a clock edge only when a valid operation arrives:
- **Overflow:** set when the signed result does not fit.
- **Advance overflow:** set when the two most significant result bits differ. This warns that the value is close to the edge of its range.
- **Sticky overflow** and **sticky advance overflow:** accumulate every overflow and every advance overflow since the last reset.

Arithmetic operations rewrite the two non-sticky flags. Logic, move and compare operations leave all four flags alone. A conditional add whose condition fails changes nothing at all.

Top module: `ovf_alu`

## Requirements
- R1: Op code 0 (add) returns (a + b) mod 2^W. Op code 1 (subtract) returns (a - b) mod 2^W. Both set the overflow flag when the signed result lies outside the signed W-bit range.
- R2: After every arithmetic operation that takes effect, the advance overflow flag equals result bit W-1 XOR result bit W-2. The arithmetic operations are op codes 0, 1, 2, 12, 13, and 3 and 4 when their condition holds.
- R3: The sticky overflow flag becomes the OR of its old value and the new overflow flag. The sticky advance flag becomes the OR of its old value and the new advance flag. No operation clears either one; only reset does.
- R4: Op code 2 (multiply) returns the low W bits of the signed 2W-bit product. It sets overflow when the product does not fit in W signed bits.
- R5: Op code 3 adds when cond is nonzero, and op code 4 adds when cond is zero; a taken conditional add flags as add. When the condition fails, write enable is 0, result equals dst, and all four flags keep their values.
- R6: Op code 5 returns b when cond is nonzero and dst otherwise. Op code 6 returns b when cond is zero and dst otherwise. Write enable is 1 only when b is selected.
- R7: Op code 7 returns 1 when a equals b and 0 otherwise. Op code 8 returns 1 when a is less than b as signed numbers and 0 otherwise.
- R8: Op codes 9, 10, 11 and 14 return a AND b, a OR b, a XOR b and b respectively. These four op codes, together with compares and conditional moves, leave all four flags unchanged.
- R9: Op code 12 (saturating add) and op code 13 (saturating subtract) set overflow exactly as op codes 0 and 1 do. On overflow they return the largest positive value (0 then all ones) or the most negative value (1 then all zeros), matching the sign of the true result.
- R10: A synchronous reset clears all four flags. While valid is low, write enable is 0 and the flags do not change.
- R11: Op code 15 is reserved. It returns dst, gives write enable 0 and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| valid_i | input | 1 | Operation strobe |
| op_i | input | 4 | Operation code |
| a_i | input | W | First operand |
| b_i | input | W | Second operand |
| cond_i | input | W | Condition operand, tested for zero |
| dst_i | input | W | Current destination value |
| result_o | output | W | Value to write, combinational |
| wr_en_o | output | 1 | Destination write enable |
| v_o | output | 1 | Overflow flag |
| sv_o | output | 1 | Sticky overflow flag |
| av_o | output | 1 | Advance overflow flag |
| sav_o | output | 1 | Sticky advance overflow flag |

## Verification
The hardest case to produce is a flag state that tells a skipped update apart from an ordinary one. A conditional add whose condition fails must leave the flags exactly as the previous operation set them. A non-sticky flag that is cleared must leave its sticky copy still set.

The bench runs the design at W=8. It sweeps every op code over a 16×16 grid of edge values around 0, ±64 and ±128. It varies the condition and the valid strobe along the grid, so a skipped conditional add often follows an overflowing one. A dedicated sequence then drives overflow followed by a clean add, and a reset in mid-stream, to separate the sticky and non-sticky flags.

// File: rtl/ovf_alu_pkg.sv
package ovf_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD   = 4'd0,
    OP_SUB   = 4'd1,
    OP_MUL   = 4'd2,
    OP_CADD  = 4'd3,
    OP_CADDZ = 4'd4,
    OP_CMOV  = 4'd5,
    OP_CMOVZ = 4'd6,
    OP_EQ    = 4'd7,
    OP_LT    = 4'd8,
    OP_AND   = 4'd9,
    OP_OR    = 4'd10,
    OP_XOR   = 4'd11,
    OP_ADDS  = 4'd12,
    OP_SUBS  = 4'd13,
    OP_MOV   = 4'd14,
    OP_NONE  = 4'd15
  } alu_op_e;

  typedef struct packed {
    logic v;
    logic sv;
    logic av;
    logic sav;
  } alu_flags_t;
endpackage

// File: rtl/ovf_alu_arith.sv
module ovf_alu_arith
  import ovf_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e        op_i,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic [W-1:0]   res_o,
  output logic           v_o,
  output logic           av_o,
  output logic           is_arith_o
);
  localparam int PW = 2 * W;
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  // Sign-flip test on the sum: operands agreed in sign, the result does not.
  function automatic logic add_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] s);
    return (s[W-1] ^ x[W-1]) & ~(x[W-1] ^ y[W-1]);
  endfunction

  // Difference overflows only when the operands differ in sign.
  function automatic logic sub_ovf(input logic [W-1:0] x, input logic [W-1:0] y,
                                   input logic [W-1:0] s);
    return (s[W-1] ^ x[W-1]) & (x[W-1] ^ y[W-1]);
  endfunction

  function automatic logic adv_ovf(input logic [W-1:0] s);
    return s[W-1] ^ s[W-2];
  endfunction

  logic [W-1:0]        sum_w, dif_w, low_w;
  logic signed [PW-1:0] prod_w;
  logic                sum_v, dif_v, mul_v;

  always_comb begin
    sum_w  = a_i + b_i;
    dif_w  = a_i - b_i;
    prod_w = $signed({{W{a_i[W-1]}}, a_i}) * $signed({{W{b_i[W-1]}}, b_i});
    low_w  = prod_w[W-1:0];
    sum_v  = add_ovf(a_i, b_i, sum_w);
    dif_v  = sub_ovf(a_i, b_i, dif_w);
    mul_v  = (prod_w[PW-1:W] != {W{low_w[W-1]}});
  end

  always_comb begin
    res_o      = '0;
    v_o        = 1'b0;
    is_arith_o = 1'b1;
    unique case (op_i)
      OP_ADD, OP_CADD, OP_CADDZ: begin res_o = sum_w; v_o = sum_v; end
      OP_SUB:                    begin res_o = dif_w; v_o = dif_v; end
      OP_MUL:                    begin res_o = low_w; v_o = mul_v; end
      OP_ADDS: begin
        v_o   = sum_v;
        res_o = sum_v ? (a_i[W-1] ? SMIN : SMAX) : sum_w;
      end
      OP_SUBS: begin
        v_o   = dif_v;
        res_o = dif_v ? (a_i[W-1] ? SMIN : SMAX) : dif_w;
      end
      default: is_arith_o = 1'b0;
    endcase
    av_o = adv_ovf(res_o);
  end
endmodule

// File: rtl/ovf_alu_misc.sv
module ovf_alu_misc
  import ovf_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] dst_i,
  output logic [W-1:0] res_o,
  output logic         take_o
);
  logic cond_nz;
  assign cond_nz = |cond_i;

  always_comb begin
    res_o  = dst_i;
    take_o = 1'b1;
    unique case (op_i)
      OP_CADD:  take_o = cond_nz;
      OP_CADDZ: take_o = ~cond_nz;
      OP_CMOV:  begin take_o = cond_nz;  res_o = cond_nz ? b_i : dst_i; end
      OP_CMOVZ: begin take_o = ~cond_nz; res_o = cond_nz ? dst_i : b_i; end
      OP_EQ:    res_o = {{(W-1){1'b0}}, (a_i == b_i)};
      OP_LT:    res_o = {{(W-1){1'b0}}, ($signed(a_i) < $signed(b_i))};
      OP_AND:   res_o = a_i & b_i;
      OP_OR:    res_o = a_i | b_i;
      OP_XOR:   res_o = a_i ^ b_i;
      OP_MOV:   res_o = b_i;
      OP_NONE:  take_o = 1'b0;
      default:  res_o = dst_i;
    endcase
  end
endmodule

// File: rtl/ovf_alu_flags.sv
module ovf_alu_flags
  import ovf_alu_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       upd_i,
  input  logic       v_i,
  input  logic       av_i,
  output alu_flags_t q_o
);
  alu_flags_t q;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (upd_i) begin
      q.v   <= v_i;
      q.av  <= av_i;
      q.sv  <= q.sv  | v_i;
      q.sav <= q.sav | av_i;
    end
  end

  assign q_o = q;

  p_sticky_sv_r3: assert property (@(posedge clk) disable iff (rst) q.sv |=> q.sv)
    else $error("sticky overflow dropped");
  p_sticky_sav_r3: assert property (@(posedge clk) disable iff (rst) q.sav |=> q.sav)
    else $error("sticky advance overflow dropped");
  p_sv_covers_v_r3: assert property (@(posedge clk) disable iff (rst) q.v |-> q.sv)
    else $error("overflow without sticky copy");
  p_sav_covers_av_r3: assert property (@(posedge clk) disable iff (rst) q.av |-> q.sav)
    else $error("advance overflow without sticky copy");
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst) !upd_i |=> $stable(q))
    else $error("flags moved without update");
endmodule

// File: rtl/ovf_alu.sv
module ovf_alu
  import ovf_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid_i,
  input  logic [3:0]   op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] cond_i,
  input  logic [W-1:0] dst_i,
  output logic [W-1:0] result_o,
  output logic         wr_en_o,
  output logic         v_o,
  output logic         sv_o,
  output logic         av_o,
  output logic         sav_o
);
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  alu_op_e    op;
  logic [W-1:0] arith_res, misc_res;
  logic       arith_v, arith_av, is_arith;
  logic       op_take;
  logic       flag_upd;
  alu_flags_t flags;

  assign op = alu_op_e'(op_i);

  ovf_alu_arith #(.W(W)) u_arith (
    .op_i(op), .a_i(a_i), .b_i(b_i),
    .res_o(arith_res), .v_o(arith_v), .av_o(arith_av), .is_arith_o(is_arith)
  );

  ovf_alu_misc #(.W(W)) u_misc (
    .op_i(op), .a_i(a_i), .b_i(b_i), .cond_i(cond_i), .dst_i(dst_i),
    .res_o(misc_res), .take_o(op_take)
  );

  assign result_o = is_arith ? (op_take ? arith_res : dst_i) : misc_res;
  assign wr_en_o  = valid_i & op_take;
  assign flag_upd = valid_i & is_arith & op_take;

  ovf_alu_flags u_flags (
    .clk(clk), .rst(rst), .upd_i(flag_upd),
    .v_i(arith_v), .av_i(arith_av), .q_o(flags)
  );

  assign v_o   = flags.v;
  assign sv_o  = flags.sv;
  assign av_o  = flags.av;
  assign sav_o = flags.sav;

  p_cadd_skip_r5: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op == OP_CADD && cond_i == '0) |-> (!wr_en_o && result_o == dst_i))
    else $error("skipped conditional add wrote");
  p_cadd_skip_flags_r5: assert property (@(posedge clk) disable iff (rst)
      (valid_i && op == OP_CADDZ && cond_i != '0) |=> $stable({v_o, sv_o, av_o, sav_o}))
    else $error("skipped conditional add moved flags");
  p_logic_noflag_r8: assert property (@(posedge clk) disable iff (rst)
      (op == OP_AND || op == OP_OR || op == OP_XOR || op == OP_MOV || op == OP_EQ)
      |=> $stable({v_o, sv_o, av_o, sav_o}))
    else $error("logic op moved flags");
  p_sat_clamp_r9: assert property (@(posedge clk) disable iff (rst)
      (valid_i && (op == OP_ADDS || op == OP_SUBS) && arith_v)
      |-> (result_o == SMAX || result_o == SMIN))
    else $error("saturating op not clamped");
  p_reserved_r11: assert property (@(posedge clk) disable iff (rst)
      (op == OP_NONE) |-> !wr_en_o)
    else $error("reserved op wrote");
endmodule

// File: tb/ovf_alu_bench.sv
`timescale 1ns/1ps
module ovf_alu_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic valid = 1'b0;
  logic [3:0] op = 4'd15;
  logic [W-1:0] a = '0, b = '0, cond = '0, dst = '0;
  logic [W-1:0] result;
  logic wr_en, v, sv, av, sav;

  int checks = 0;
  int failures = 0;
  bit mv = 0, msv = 0, mav = 0, msav = 0;

  always #2.5 clk = ~clk;

  ovf_alu #(.W(W)) u_ovf_alu (
    .clk(clk), .rst(rst), .valid_i(valid), .op_i(op), .a_i(a), .b_i(b),
    .cond_i(cond), .dst_i(dst), .result_o(result), .wr_en_o(wr_en),
    .v_o(v), .sv_o(sv), .av_o(av), .sav_o(sav)
  );

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] pick(input int i);
    case (i)
      0: return 8'h00;  1: return 8'h01;  2: return 8'h02;  3: return 8'h3F;
      4: return 8'h40;  5: return 8'h41;  6: return 8'h7E;  7: return 8'h7F;
      8: return 8'h80;  9: return 8'h81; 10: return 8'hBF; 11: return 8'hC0;
      12: return 8'hC1; 13: return 8'hFE; 14: return 8'hFF; default: return 8'h55;
    endcase
  endfunction

  task automatic run_op(input logic [3:0] o, input logic [7:0] x, input logic [7:0] y,
                        input logic [7:0] c, input logic [7:0] d, input bit vld);
    int sa, sb, s;
    bit arith, take, ov;
    logic [7:0] r;
    string tag;
    @(negedge clk);
    op = o; a = x; b = y; cond = c; dst = d; valid = vld;
    sa = int'($signed(x)); sb = int'($signed(y));
    arith = 0; take = 1; ov = 0; r = d; tag = "R8";
    case (o)
      4'd0, 4'd3, 4'd4: begin
        s = sa + sb; r = s[7:0]; ov = (s > 127 || s < -128); arith = 1;
        tag = (o == 4'd0) ? "R1" : "R5";
        if (o == 4'd3) take = (c != 0);
        if (o == 4'd4) take = (c == 0);
        if (!take) r = d;
      end
      4'd1: begin s = sa - sb; r = s[7:0]; ov = (s > 127 || s < -128); arith = 1; tag = "R1"; end
      4'd2: begin s = sa * sb; r = s[7:0]; ov = (s > 127 || s < -128); arith = 1; tag = "R4"; end
      4'd12, 4'd13: begin
        s = (o == 4'd12) ? sa + sb : sa - sb; arith = 1; tag = "R9";
        if (s > 127) begin r = 8'h7F; ov = 1; end
        else if (s < -128) begin r = 8'h80; ov = 1; end
        else r = s[7:0];
      end
      4'd5: begin take = (c != 0); r = take ? y : d; tag = "R6"; end
      4'd6: begin take = (c == 0); r = take ? y : d; tag = "R6"; end
      4'd7: begin r = (x == y) ? 8'd1 : 8'd0; tag = "R7"; end
      4'd8: begin r = (sa < sb) ? 8'd1 : 8'd0; tag = "R7"; end
      4'd9:  r = x & y;
      4'd10: r = x | y;
      4'd11: r = x ^ y;
      4'd14: r = y;
      default: begin take = 0; r = d; tag = "R11"; end
    endcase
    #1;
    chk(result === r, {tag, " result"}, int'(result), int'(r));
    chk(wr_en === (vld & take), vld ? {tag, " write enable"} : "R10 write enable idle",
        int'(wr_en), int'(vld & take));
    if (vld && arith && take) begin
      mv = ov; mav = r[7] ^ r[6]; msv = msv | ov; msav = msav | mav;
    end
    @(posedge clk);
    #1;
    chk(v === mv, vld ? {tag, " overflow flag"} : "R10 overflow idle", int'(v), int'(mv));
    chk(av === mav, "R2 advance flag", int'(av), int'(mav));
    chk(sv === msv, "R3 sticky overflow", int'(sv), int'(msv));
    chk(sav === msav, "R3 sticky advance", int'(sav), int'(msav));
  endtask

  initial begin
    #(5.0 * 150000);
    checks++; failures++;
    $display("FAIL watchdog expired got=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk({v, sv, av, sav} === 4'b0, "R10 reset flags", int'({v, sv, av, sav}), 0);

    for (int o = 0; o < 16; o++) begin
      for (int i = 0; i < 16; i++) begin
        for (int j = 0; j < 16; j++) begin
          run_op(4'(o), pick(i), pick(j),
                 ((i + j) % 3 == 0) ? 8'h00 : (8'h10 | 8'(j)),
                 8'(~pick(i) ^ 8'(j)),
                 ((i * 16 + j) % 11) != 5);
        end
      end
    end

    // R3: overflow, then a clean add keeps the sticky copies
    run_op(4'd0, 8'h7F, 8'h01, 8'h00, 8'h00, 1'b1);
    run_op(4'd0, 8'h01, 8'h01, 8'h00, 8'h00, 1'b1);
    chk(v === 1'b0 && sv === 1'b1, "R3 sticky after clean add", int'({v, sv}), 1);
    // R5: a skipped conditional add right after overflow keeps everything
    run_op(4'd2, 8'h40, 8'h04, 8'h00, 8'h00, 1'b1);
    run_op(4'd3, 8'h01, 8'h01, 8'h00, 8'h33, 1'b1);
    chk(v === 1'b1, "R5 skipped add keeps overflow", int'(v), 1);

    // R10: reset clears sticky state
    @(negedge clk); rst = 1'b1; valid = 1'b0;
    @(posedge clk); #1; rst = 1'b0;
    mv = 0; msv = 0; mav = 0; msav = 0;
    chk({v, sv, av, sav} === 4'b0, "R10 reset after activity", int'({v, sv, av, sav}), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule